// File: doc/BRIEF.md
# Page Table Translation Unit

This block turns a virtual address into a physical address by reading one entry of a single-level page table. The table lives in an external word-addressed memory. A requester hands over a virtual address, an access kind (load, store or instruction fetch) and a privilege flag. The unit splits the address into a page number and a page offset. It adds the page number to the table base to form the word address of the entry, and issues one read for it. When the entry comes back, the unit checks the entry's present flag and its permission flags. It then returns either the physical address or a typed fault.

Requests, table reads and responses each use a valid/ready handshake. Only one translation is in flight at a time. The table base is sampled on the cycle the request is accepted, so the requester may change it once that handshake completes.

Top module: `ptw_translate`

## Requirements
- R1: While reset (synchronous, active high) is asserted and on the first cycle after it, the unit is idle: req_ready is 1, and rsp_valid and mem_rd_valid are 0.
- R2: The low PAGE_BITS (12) bits of the virtual address are the page offset. They appear unchanged in the low bits of rsp_paddr on every fault-free response.
- R3: Each accepted request causes exactly one table read. The read address is pt_base + vaddr[31:12], computed modulo 2^32, and it stays valid and stable until mem_rd_ready is seen.
- R4: Table entry layout: bit 0 is present, bit 1 is supervisor-only, bit 2 is readable, bit 3 is writable, bit 4 is executable, and bits 31:12 are the physical page number. A permitted access returns rsp_paddr = {entry[31:12], offset} with rsp_fault = 0.
- R5: An entry with the present bit at 0 returns rsp_fault = 1 (not present), whatever its permission bits say.
- R6: A user access (req_sup = 0) to a present entry whose supervisor-only bit is 1 returns rsp_fault = 2 (protection).
- R7: Access kind codes: 0 is a load and needs the readable bit, 1 is a store and needs the writable bit, 2 is a fetch and needs the executable bit, and 3 is checked exactly like a load. A missing required bit returns rsp_fault = 2.
- R8: A supervisor access (req_sup = 1) to a supervisor-only entry is allowed and is judged by the R7 rules alone.
- R9: From acceptance until its response is taken, req_ready is 0. A change of pt_base after acceptance does not affect the read address.
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_paddr and rsp_fault hold their values.
- R11: Every faulted response carries rsp_paddr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| req_sup | input | 1 | 1 = supervisor access |
| pt_base | input | 32 | Word address of table entry 0 |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Word address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry contents |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
The bench targets entries that are absent but carry every permission bit. A unit that tests permissions before the present bit would report a protection fault for these instead of a not-present fault. It also sends user accesses to supervisor-only pages, fetches and stores to pages that lack the matching bit, and the reserved access code. A wrong permission select would let such accesses through or fault legal loads. Table reads are stalled at random, and responses are held off at random. The base is also changed right after acceptance. These cases expose a read address that drifts, a response that changes while stalled, or a second request accepted too early. Addresses at the top of the range, and table bases that wrap, test the offset pass-through and the modulo addition of the entry address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Entry flag positions; the physical page number sits in the top bits.
    localparam int unsigned PTE_PRESENT = 0;
    localparam int unsigned PTE_SUPER   = 1;
    localparam int unsigned PTE_RD      = 2;
    localparam int unsigned PTE_WR      = 3;
    localparam int unsigned PTE_EX      = 4;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_ISSUE = 2'd1,
        XS_WAIT  = 2'd2,
        XS_RESP  = 2'd3
    } xl_state_e;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int MEM_AW    = 32,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input  logic [VA_W-1:0]      vaddr,
    input  logic [MEM_AW-1:0]    base,
    output logic [VPN_W-1:0]     vpn,
    output logic [PAGE_BITS-1:0] offset,
    output logic [MEM_AW-1:0]    entry_addr
);

    logic [MEM_AW-1:0] vpn_ext;

    assign vpn    = vaddr[VA_W-1:PAGE_BITS];
    assign offset = vaddr[PAGE_BITS-1:0];

    generate
        if (MEM_AW > VPN_W) begin : g_widen
            assign vpn_ext = {{(MEM_AW-VPN_W){1'b0}}, vpn};
        end else if (MEM_AW == VPN_W) begin : g_same
            assign vpn_ext = vpn;
        end else begin : g_trunc
            assign vpn_ext = vpn[MEM_AW-1:0];
        end
    endgenerate

    // One word per entry: index the table directly by page number.
    assign entry_addr = base + vpn_ext;

endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
#(
    parameter int PTE_W     = 32,
    parameter int PAGE_BITS = 12,
    parameter int PPN_W     = 20,
    localparam int PA_W     = PPN_W + PAGE_BITS
) (
    input  logic [PTE_W-1:0]     pte,
    input  logic [PAGE_BITS-1:0] offset,
    input  acc_e                 acc,
    input  logic                 sup,
    output logic [PA_W-1:0]      paddr,
    output fault_e               fault
);

    logic             need_bit;
    logic [PPN_W-1:0] ppn;

    assign ppn = pte[PTE_W-1 -: PPN_W];

    always_comb begin
        unique case (acc)
            ACC_STORE: need_bit = pte[PTE_WR];
            ACC_FETCH: need_bit = pte[PTE_EX];
            default:   need_bit = pte[PTE_RD];
        endcase
    end

    // The absent check comes first so that it beats any permission outcome.
    always_comb begin
        if (!pte[PTE_PRESENT]) begin
            fault = FLT_ABSENT;
        end else if (!sup && pte[PTE_SUPER]) begin
            fault = FLT_PROT;
        end else if (!need_bit) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end

    assign paddr = (fault == FLT_NONE) ? {ppn, offset} : '0;

endmodule

// File: rtl/ptw_translate.sv
module ptw_translate
    import ptw_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PPN_W     = 20,
    parameter int MEM_AW    = 32,
    parameter int PTE_W     = 32,
    localparam int PA_W     = PPN_W + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_sup,
    input  logic [MEM_AW-1:0] pt_base,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault
);

    localparam int VPN_W = VA_W - PAGE_BITS;

    typedef struct packed {
        xl_state_e         st;
        logic [VA_W-1:0]   va;
        acc_e              acc;
        logic              sup;
        logic [MEM_AW-1:0] ea;
        logic [PA_W-1:0]   pa;
        fault_e            flt;
    } regs_t;

    regs_t r_d, r_q;

    logic [VPN_W-1:0]     req_vpn;
    logic [PAGE_BITS-1:0] req_off;
    logic [MEM_AW-1:0]    req_ea;
    logic [PA_W-1:0]      chk_pa;
    fault_e               chk_flt;

    ptw_va_split #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .MEM_AW    (MEM_AW)
    ) u_split (
        .vaddr      (req_vaddr),
        .base       (pt_base),
        .vpn        (req_vpn),
        .offset     (req_off),
        .entry_addr (req_ea)
    );

    ptw_pte_check #(
        .PTE_W     (PTE_W),
        .PAGE_BITS (PAGE_BITS),
        .PPN_W     (PPN_W)
    ) u_check (
        .pte    (mem_rsp_data),
        .offset (r_q.va[PAGE_BITS-1:0]),
        .acc    (r_q.acc),
        .sup    (r_q.sup),
        .paddr  (chk_pa),
        .fault  (chk_flt)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            XS_IDLE: begin
                if (req_valid) begin
                    r_d.va  = req_vaddr;
                    r_d.acc = acc_e'(req_acc);
                    r_d.sup = req_sup;
                    r_d.ea  = req_ea;
                    r_d.st  = XS_ISSUE;
                end
            end
            XS_ISSUE: begin
                if (mem_rd_ready) begin
                    r_d.st = XS_WAIT;
                end
            end
            XS_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.pa  = chk_pa;
                    r_d.flt = chk_flt;
                    r_d.st  = XS_RESP;
                end
            end
            default: begin
                if (rsp_ready) begin
                    r_d.st = XS_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: XS_IDLE, va: '0, acc: ACC_LOAD, sup: 1'b0,
                     ea: '0, pa: '0, flt: FLT_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.st == XS_IDLE);
    assign mem_rd_valid = (r_q.st == XS_ISSUE);
    assign mem_rd_addr  = r_q.ea;
    assign rsp_valid    = (r_q.st == XS_RESP);
    assign rsp_paddr    = r_q.pa;
    assign rsp_fault    = r_q.flt;

    // R9
    single_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R11
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd0) |->
            (rsp_paddr[PAGE_BITS-1:0] == r_q.va[PAGE_BITS-1:0]));

    // R5
    absent_first_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == XS_WAIT && mem_rsp_valid && !mem_rsp_data[PTE_PRESENT])
            |=> (rsp_valid && rsp_fault == 2'd1));

endmodule

// File: tb/ptw_translate_test.sv
module ptw_translate_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_sup;
    logic [31:0] req_vaddr, pt_base;
    logic [1:0]  req_acc;
    logic        mem_rd_valid, mem_rd_ready, mem_rsp_valid;
    logic [31:0] mem_rd_addr, mem_rsp_data;
    logic        rsp_valid, rsp_ready;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int total = 0;
    int bad   = 0;

    logic [31:0] tbl [0:63];
    logic [31:0] tbase;
    logic [31:0] cap_addr;
    int          rd_count = 0;
    int          lat = 0;
    bit          pend = 0;

    always #5 clk = ~clk;

    ptw_translate uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_sup(req_sup),
        .pt_base(pt_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lookup(logic [31:0] a);
        logic [31:0] d = a - tbase;
        if (d < 32'd64) return tbl[d[5:0]];
        return 32'h0;
    endfunction

    // Reference result {fault, paddr} from the requirements.
    function automatic logic [33:0] reference(logic [31:0] e, logic [31:0] va,
                                              logic [1:0] acc, logic sup);
        logic ok;
        if (!e[0]) return {2'd1, 32'h0};                 // R5
        if (!sup && e[1]) return {2'd2, 32'h0};          // R6
        case (acc)
            2'd1:    ok = e[3];
            2'd2:    ok = e[4];
            default: ok = e[2];                          // R7 code 3 as load
        endcase
        if (!ok) return {2'd2, 32'h0};
        return {2'd0, e[31:12], va[11:0]};               // R4, R2
    endfunction

    // Memory model: random read stalls and random return latency.
    always @(negedge clk) begin
        if (rst) begin
            mem_rsp_valid = 1'b0;
            mem_rd_ready  = 1'b0;
            pend = 0;
        end else begin
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = lookup(cap_addr);
                    pend = 0;
                end else begin
                    lat--;
                end
            end
            mem_rd_ready = ($urandom % 4) != 0;
            if (!pend && mem_rd_valid && mem_rd_ready) begin
                cap_addr = mem_rd_addr;
                pend = 1;
                lat = $urandom % 3;
                rd_count++;
            end
        end
    end

    task automatic xlate(logic [31:0] va, logic [1:0] acc, logic sup);
        logic [33:0] exp;
        logic [31:0] hold_pa;
        logic [1:0]  hold_f;
        int          rc0;
        int          hold;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_acc   = acc;
        req_sup   = sup;
        pt_base   = tbase;
        rc0       = rd_count;
        @(negedge clk);
        req_valid = 1'b0;
        pt_base   = $urandom;                            // R9 late base change
        check(req_ready == 1'b0, "R9 busy after accept", {63'd0, req_ready}, 64'd0);
        exp = reference(lookup(tbase + {12'd0, va[31:12]}), va, acc, sup);
        while (!rsp_valid) @(negedge clk);
        check(cap_addr == tbase + {12'd0, va[31:12]}, "R3 entry address",
              {32'd0, cap_addr}, {32'd0, tbase + {12'd0, va[31:12]}});
        check(rd_count == rc0 + 1, "R3 one read", rd_count, rc0 + 1);
        hold_pa = rsp_paddr;
        hold_f  = rsp_fault;
        hold    = $urandom % 3;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_paddr == hold_pa && rsp_fault == hold_f,
                  "R10 response held", {rsp_valid, rsp_fault, rsp_paddr},
                  {1'b1, hold_f, hold_pa});
            check(req_ready == 1'b0, "R9 busy while response", {63'd0, req_ready}, 64'd0);
        end
        check(rsp_fault == exp[33:32], "R5 R6 R7 R8 fault code",
              {62'd0, rsp_fault}, {62'd0, exp[33:32]});
        check(rsp_paddr == exp[31:0], "R4 R2 R11 physical address",
              {32'd0, rsp_paddr}, {32'd0, exp[31:0]});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 idle after take",
              {62'd0, rsp_valid, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        process::self().srandom(32'd7321);
        rst = 1'b1;
        req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_sup = 1'b0;
        pt_base = '0; rsp_ready = 1'b0; mem_rsp_data = '0;
        tbase = 32'h0000_1000;
        for (int i = 0; i < 64; i++) tbl[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(req_ready && !rsp_valid && !mem_rd_valid, "R1 reset state",
              {61'd0, req_ready, rsp_valid, mem_rd_valid}, 64'd4);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_rd_valid, "R1 after reset",
              {61'd0, req_ready, rsp_valid, mem_rd_valid}, 64'd4);

        // Directed corners
        tbl[0] = 32'hABCDE_01D;                 // present, RD WR EX, user page
        xlate(32'h0000_0FFF, 2'd0, 1'b0);       // R4 load hit, max offset
        tbl[1] = 32'h12345_01E;                 // absent, every permission (R5)
        xlate(32'h0000_1ABC, 2'd1, 1'b1);
        tbl[2] = 32'h55555_017;                 // present SUP RD EX
        xlate(32'h0000_2004, 2'd0, 1'b0);       // R6 user to super page
        xlate(32'h0000_2004, 2'd0, 1'b1);       // R8 super allowed
        xlate(32'h0000_2004, 2'd1, 1'b1);       // R7 store without WR
        tbl[3] = 32'h77777_00D;                 // present RD WR, no EX
        xlate(32'h0000_3010, 2'd2, 1'b0);       // R7 fetch without EX
        xlate(32'h0000_3010, 2'd3, 1'b0);       // R7 code 3 like load
        tbl[4] = 32'h99999_019;                 // present WR EX, no RD
        xlate(32'h0000_4020, 2'd3, 1'b0);       // R7 code 3 needs RD
        xlate(32'h0000_4020, 2'd2, 1'b0);
        tbase = 32'hFFFF_FFF0;                  // R3 wrapping base
        tbl[63] = 32'hFFFFF_01F;
        xlate(32'h0003_FFFF, 2'd0, 1'b1);       // entry addr wraps to 0x2F
        xlate(32'hFFFF_F123, 2'd0, 1'b1);       // far page: zero entry

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] va;
            if (n % 50 == 0) begin
                tbase = $urandom;
                for (int i = 0; i < 64; i++) begin
                    tbl[i] = $urandom;
                    if ($urandom % 8 != 0) tbl[i][0] = 1'b1;
                end
            end
            va = $urandom;
            if ($urandom % 8 != 0) va[31:12] = 20'($urandom % 64);
            xlate(va, 2'($urandom), 1'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule